// File: doc/BRIEF.md
# Flash Failure Address Capture Register

This block holds the double-word address of the first failure that a flash memory controller reports. Three sources can report a failure: an uncorrectable ECC error on a read, a single-bit ECC correction on a read, and a program/erase state machine operation that finishes without passing. Each source gives a one-cycle event pulse with a byte address and a flag that says whether the access was in the main array or the shadow array. The controller also supplies its two sticky ECC status flags and an ECC logic-test enable. These inputs decide whether a capture or a host write may change the stored value.

Only address bits 20 down to 3 are kept, so the register always names a 64-bit double word. A host write port lets software load the address field, for example to exercise ECC test logic. A combinational read port returns the stored value in a fixed word layout. An accepted capture or write shows on the outputs one clock after the edge that samples it. The event inputs and the host port are plain pulse interfaces. They have no valid/ready handshake and no back-pressure, and an event is either taken or dropped in the cycle it appears.

Top module: `flash_fail_addr_capture`

## Requirements
- R1: After reset the stored address field, the array-space flag and the read word are all zero.
- R2: A capture stores bits 20:3 of the reporting source's byte address. Bits 2:0 are never stored. The new value is visible one cycle after the event.
- R3: The array-space flag (0 = main array, 1 = shadow array) is captured together with the address. It changes only on a hardware capture and never on a host write.
- R4: When several sources qualify in the same cycle, the uncorrectable ECC event wins, then the single-bit correction, then the state machine failure.
- R5: An uncorrectable ECC event captures only while the uncorrectable flag is clear. A single-bit correction or a state machine failure captures only while both ECC flags are clear.
- R6: A state machine completion captures only when its pass indication is 0. A completion with pass = 1 changes nothing.
- R7: A host write loads bits 20:3 of the write data into the address field only while both ECC flags are clear. While either flag is set, the write is ignored.
- R8: The state machine pass indication has no effect on whether a host write is accepted.
- R9: While the ECC test enable is 1, no source event changes the register, but host writes still follow R7.
- R10: If a hardware capture and an accepted host write happen in the same cycle, the hardware capture is stored.
- R11: The read word carries the address field in bits 20:3 and the array-space flag in bit 31. All other bits read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ecc_evt_i | input | 1 | Uncorrectable ECC event pulse |
| ecc_addr_i | input | 21 | Byte address of the uncorrectable event |
| ecc_shadow_i | input | 1 | Array space of the uncorrectable event (1 = shadow) |
| sbc_evt_i | input | 1 | Single-bit correction event pulse |
| sbc_addr_i | input | 21 | Byte address of the correction |
| sbc_shadow_i | input | 1 | Array space of the correction |
| sm_done_i | input | 1 | State machine operation finished |
| sm_pass_i | input | 1 | State machine pass indication (0 = failed) |
| sm_addr_i | input | 21 | Byte address of the state machine operation |
| sm_shadow_i | input | 1 | Array space of the state machine operation |
| ecc_flag_i | input | 1 | Sticky uncorrectable-ECC status flag |
| sbc_flag_i | input | 1 | Sticky single-bit-correction status flag |
| ecc_test_en_i | input | 1 | ECC logic-test enable, blocks all captures |
| host_wr_i | input | 1 | Host write strobe |
| host_wdata_i | input | 32 | Host write word (bits 20:3 used) |
| host_rdata_o | output | 32 | Read word |
| cap_addr_o | output | 18 | Stored address bits 20:3 |
| cap_shadow_o | output | 1 | Stored array-space flag |

## Verification
The bench sweeps every combination of the three events, the pass indication, both sticky flags, the test enable and the host strobe. Before each combination it loads a known value, so any change or lack of change can be seen. A design with the priority order swapped would store the single-bit or state machine address when two events collide. A lock that ignores the single-bit flag would let a correction overwrite the first failure, and a lock that also reacted to the pass indication would reject valid host writes. A design that let the host write win a collision, changed the array flag on a write, or kept capturing in test mode would show a wrong read word, because the host data and the array flag are chosen to differ from every source value.

// File: rtl/ffac_pkg.sv
package ffac_pkg;
  // Source indices in priority order: lower index wins.
  localparam int unsigned FFAC_NSRC = 3;
  typedef enum int unsigned {
    SRC_ECC = 0,
    SRC_SBC = 1,
    SRC_SM  = 2
  } ffac_src_e;
endpackage

// File: rtl/ffac_qualify.sv
module ffac_qualify
  import ffac_pkg::*;
(
  input  logic                 ecc_evt_i,
  input  logic                 sbc_evt_i,
  input  logic                 sm_done_i,
  input  logic                 sm_pass_i,
  input  logic                 ecc_flag_i,
  input  logic                 sbc_flag_i,
  input  logic                 ecc_test_en_i,
  input  logic                 host_wr_i,
  output logic [FFAC_NSRC-1:0] req_o,
  output logic                 sw_load_o
);
  logic locked;
  logic hw_allowed;

  always_comb begin
    locked     = ecc_flag_i | sbc_flag_i;
    hw_allowed = ~ecc_test_en_i;
    req_o            = '0;
    // An uncorrectable event may replace a single-bit capture.
    req_o[SRC_ECC]   = hw_allowed & ecc_evt_i & ~ecc_flag_i;
    req_o[SRC_SBC]   = hw_allowed & sbc_evt_i & ~locked;
    req_o[SRC_SM]    = hw_allowed & sm_done_i & ~sm_pass_i & ~locked;
    // The pass indication plays no part in write permission.
    sw_load_o        = host_wr_i & ~locked;
  end
endmodule

// File: rtl/ffac_prio_sel.sv
module ffac_prio_sel #(
  parameter int unsigned NSRC = 3,
  parameter int unsigned W    = 19
) (
  input  logic [NSRC-1:0]        req_i,
  input  logic [NSRC-1:0][W-1:0] payload_i,
  output logic                   hit_o,
  output logic [W-1:0]           sel_o
);
  always_comb begin
    hit_o = 1'b0;
    sel_o = '0;
    // Walk from lowest priority upward so index 0 is applied last.
    for (int i = int'(NSRC) - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        hit_o = 1'b1;
        sel_o = payload_i[i];
      end
    end
  end
endmodule

// File: rtl/ffac_capture_reg.sv
module ffac_capture_reg #(
  parameter int unsigned FIELD_W = 18
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               hw_load_i,
  input  logic [FIELD_W-1:0] hw_addr_i,
  input  logic               hw_shadow_i,
  input  logic               sw_load_i,
  input  logic [FIELD_W-1:0] sw_addr_i,
  output logic [FIELD_W-1:0] addr_o,
  output logic               shadow_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o   <= '0;
      shadow_o <= 1'b0;
    end else if (hw_load_i) begin
      addr_o   <= hw_addr_i;
      shadow_o <= hw_shadow_i;
    end else if (sw_load_i) begin
      addr_o   <= sw_addr_i;
    end
  end
endmodule

// File: rtl/flash_fail_addr_capture.sv
module flash_fail_addr_capture
  import ffac_pkg::*;
#(
  parameter int unsigned ADDR_HI    = 20,
  parameter int unsigned ADDR_LO    = 3,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned SHADOW_BIT = 31,
  localparam int unsigned EVT_AW    = ADDR_HI + 1,
  localparam int unsigned FIELD_W   = ADDR_HI - ADDR_LO + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ecc_evt_i,
  input  logic [EVT_AW-1:0]  ecc_addr_i,
  input  logic               ecc_shadow_i,
  input  logic               sbc_evt_i,
  input  logic [EVT_AW-1:0]  sbc_addr_i,
  input  logic               sbc_shadow_i,
  input  logic               sm_done_i,
  input  logic               sm_pass_i,
  input  logic [EVT_AW-1:0]  sm_addr_i,
  input  logic               sm_shadow_i,
  input  logic               ecc_flag_i,
  input  logic               sbc_flag_i,
  input  logic               ecc_test_en_i,
  input  logic               host_wr_i,
  input  logic [DATA_W-1:0]  host_wdata_i,
  output logic [DATA_W-1:0]  host_rdata_o,
  output logic [FIELD_W-1:0] cap_addr_o,
  output logic               cap_shadow_o
);
  localparam int unsigned PAY_W = FIELD_W + 1;

  logic [FFAC_NSRC-1:0]            req;
  logic [FFAC_NSRC-1:0][PAY_W-1:0] payload;
  logic                            hw_hit;
  logic [PAY_W-1:0]                hw_pay;
  logic                            sw_load;

  // Byte-offset bits and unused write bits are dropped on purpose.
  logic unused_low;
  assign unused_low = ^{ecc_addr_i[ADDR_LO-1:0], sbc_addr_i[ADDR_LO-1:0],
                        sm_addr_i[ADDR_LO-1:0], host_wdata_i[ADDR_LO-1:0],
                        host_wdata_i[DATA_W-1:ADDR_HI+1]};

  always_comb begin
    payload          = '0;
    payload[SRC_ECC] = {ecc_shadow_i, ecc_addr_i[ADDR_HI:ADDR_LO]};
    payload[SRC_SBC] = {sbc_shadow_i, sbc_addr_i[ADDR_HI:ADDR_LO]};
    payload[SRC_SM]  = {sm_shadow_i,  sm_addr_i[ADDR_HI:ADDR_LO]};
  end

  ffac_qualify u_qual (
    .ecc_evt_i     (ecc_evt_i),
    .sbc_evt_i     (sbc_evt_i),
    .sm_done_i     (sm_done_i),
    .sm_pass_i     (sm_pass_i),
    .ecc_flag_i    (ecc_flag_i),
    .sbc_flag_i    (sbc_flag_i),
    .ecc_test_en_i (ecc_test_en_i),
    .host_wr_i     (host_wr_i),
    .req_o         (req),
    .sw_load_o     (sw_load)
  );

  ffac_prio_sel #(.NSRC(FFAC_NSRC), .W(PAY_W)) u_sel (
    .req_i     (req),
    .payload_i (payload),
    .hit_o     (hw_hit),
    .sel_o     (hw_pay)
  );

  ffac_capture_reg #(.FIELD_W(FIELD_W)) u_reg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .hw_load_i   (hw_hit),
    .hw_addr_i   (hw_pay[FIELD_W-1:0]),
    .hw_shadow_i (hw_pay[FIELD_W]),
    .sw_load_i   (sw_load),
    .sw_addr_i   (host_wdata_i[ADDR_HI:ADDR_LO]),
    .addr_o      (cap_addr_o),
    .shadow_o    (cap_shadow_o)
  );

  always_comb begin
    host_rdata_o                    = '0;
    host_rdata_o[ADDR_HI:ADDR_LO]   = cap_addr_o;
    host_rdata_o[SHADOW_BIT]        = cap_shadow_o;
  end
endmodule

// File: rtl/ffac_checker.sv
module ffac_checker #(
  parameter int unsigned ADDR_HI    = 20,
  parameter int unsigned ADDR_LO    = 3,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned SHADOW_BIT = 31,
  localparam int unsigned EVT_AW    = ADDR_HI + 1,
  localparam int unsigned FIELD_W   = ADDR_HI - ADDR_LO + 1
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               ecc_evt_i,
  input logic [EVT_AW-1:0]  ecc_addr_i,
  input logic               ecc_shadow_i,
  input logic               sbc_evt_i,
  input logic               sm_done_i,
  input logic               sm_pass_i,
  input logic               ecc_flag_i,
  input logic               ecc_test_en_i,
  input logic               host_wr_i,
  input logic [DATA_W-1:0]  host_rdata_o,
  input logic [FIELD_W-1:0] cap_addr_o,
  input logic               cap_shadow_o
);
  // R4: a qualifying uncorrectable event is what gets stored.
  a_r4_ecc_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ecc_evt_i && !ecc_flag_i && !ecc_test_en_i) |=>
      (cap_addr_o == $past(ecc_addr_i[ADDR_HI:ADDR_LO]) &&
       cap_shadow_o == $past(ecc_shadow_i)));

  // R5 and R7: with the uncorrectable flag set nothing can change the value.
  a_r5_ecc_lock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ecc_flag_i |=> ($stable(cap_addr_o) && $stable(cap_shadow_o)));

  // R9: test mode blocks captures; without a write the value holds.
  a_r9_test_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ecc_test_en_i && !host_wr_i) |=> ($stable(cap_addr_o) && $stable(cap_shadow_o)));

  // R6: a passing completion with no other activity changes nothing.
  a_r6_pass_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sm_done_i && sm_pass_i && !ecc_evt_i && !sbc_evt_i && !host_wr_i) |=>
      $stable(cap_addr_o));

  // R3: the array flag moves only on a hardware capture.
  a_r3_shadow_hw_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ecc_evt_i && !sbc_evt_i && !(sm_done_i && !sm_pass_i)) |=> $stable(cap_shadow_o));

  // R11: read word layout.
  a_r11_read_layout: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_rdata_o[ADDR_LO-1:0] == '0 && host_rdata_o[ADDR_HI:ADDR_LO] == cap_addr_o &&
     host_rdata_o[SHADOW_BIT] == cap_shadow_o));
endmodule

bind flash_fail_addr_capture ffac_checker #(
  .ADDR_HI(ADDR_HI), .ADDR_LO(ADDR_LO), .DATA_W(DATA_W), .SHADOW_BIT(SHADOW_BIT)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .ecc_evt_i     (ecc_evt_i),
  .ecc_addr_i    (ecc_addr_i),
  .ecc_shadow_i  (ecc_shadow_i),
  .sbc_evt_i     (sbc_evt_i),
  .sm_done_i     (sm_done_i),
  .sm_pass_i     (sm_pass_i),
  .ecc_flag_i    (ecc_flag_i),
  .ecc_test_en_i (ecc_test_en_i),
  .host_wr_i     (host_wr_i),
  .host_rdata_o  (host_rdata_o),
  .cap_addr_o    (cap_addr_o),
  .cap_shadow_o  (cap_shadow_o)
);

// File: tb/flash_fail_addr_capture_tb_top.sv
module flash_fail_addr_capture_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ecc_evt = 0, ecc_sh = 0, sbc_evt = 0, sbc_sh = 0;
  logic        sm_done = 0, sm_pass = 0, sm_sh = 0;
  logic        ecc_flag = 0, sbc_flag = 0, test_en = 0, hwr = 0;
  logic [20:0] ecc_a = 0, sbc_a = 0, sm_a = 0;
  logic [31:0] wdata = 0;
  logic [31:0] rdata;
  logic [17:0] cap_addr;
  logic        cap_sh;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  flash_fail_addr_capture dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .ecc_evt_i(ecc_evt), .ecc_addr_i(ecc_a), .ecc_shadow_i(ecc_sh),
    .sbc_evt_i(sbc_evt), .sbc_addr_i(sbc_a), .sbc_shadow_i(sbc_sh),
    .sm_done_i(sm_done), .sm_pass_i(sm_pass), .sm_addr_i(sm_a), .sm_shadow_i(sm_sh),
    .ecc_flag_i(ecc_flag), .sbc_flag_i(sbc_flag), .ecc_test_en_i(test_en),
    .host_wr_i(hwr), .host_wdata_i(wdata), .host_rdata_o(rdata),
    .cap_addr_o(cap_addr), .cap_shadow_o(cap_sh)
  );

  function automatic logic [31:0] word(input logic [17:0] a, input logic s);
    return {s, 10'b0, a, 3'b0};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    ecc_evt = 0; sbc_evt = 0; sm_done = 0; sm_pass = 0; hwr = 0;
    ecc_flag = 0; sbc_flag = 0; test_en = 0;
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", rdata, 32'h0);
    check("R1", {13'b0, cap_sh, cap_addr}, 32'h0);
    rst_n = 1'b1;

    // R11 / R2: low address bits dropped, layout fixed.
    @(negedge clk);
    idle(); sm_done = 1; sm_pass = 0; sm_a = 21'h1ABCDF; sm_sh = 1;
    @(negedge clk); idle();
    check("R11", rdata, word(18'h3579B, 1'b1));

    for (int v = 0; v < 256; v++) begin
      logic ee, se, sd, sp, ef, sf, te, hw, cap, lock;
      logic [17:0] ea; logic es;
      string tag;
      // Preload a known value through a clean single-bit capture.
      idle(); sbc_evt = 1; sbc_a = 21'h1FFFF8; sbc_sh = 0;
      @(negedge clk);
      check("R2", rdata, word(18'h3FFFF, 1'b0));
      {ee, se, sd, sp, ef, sf, te, hw} = 8'(v);
      ecc_evt = ee; sbc_evt = se; sm_done = sd; sm_pass = sp;
      ecc_flag = ef; sbc_flag = sf; test_en = te; hwr = hw;
      ecc_a = 21'h100000 | 21'(v << 3) | 21'h5; ecc_sh = 1;
      sbc_a = 21'h080000 | 21'(v << 3) | 21'h3; sbc_sh = 1;
      sm_a  = 21'h040000 | 21'(v << 3) | 21'h6; sm_sh = 1;
      wdata = 32'h8000_0007 | (32'h010000 | 32'(v << 3));
      lock = ef | sf;
      ea = 18'h3FFFF; es = 1'b0; cap = 1'b1; tag = "R3";
      if (!te && ee && !ef) begin
        ea = ecc_a[20:3]; es = 1; tag = (se || (sd && !sp)) ? "R4" : "R5";
      end else if (!te && se && !lock) begin
        ea = sbc_a[20:3]; es = 1; tag = (sd && !sp) ? "R4" : "R2";
      end else if (!te && sd && !sp && !lock) begin
        ea = sm_a[20:3]; es = 1; tag = "R6";
      end else begin
        cap = 1'b0;
        if (hw && !lock) begin
          ea = wdata[20:3]; tag = te ? "R9" : (sp ? "R8" : "R7");
        end else if (te && (ee || se || sd)) tag = "R9";
        else if (lock && (ee || se || sd || hw)) tag = "R5";
        else if (sd && sp) tag = "R6";
      end
      if (cap && hw && !lock) tag = "R10";
      @(negedge clk);
      check(tag, rdata, word(ea, es));
    end

    idle();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule